// File: doc/BRIEF.md
# Waveform Readout Address Sequencer

This block steps through the cell and channel addresses needed to move a captured waveform out of a switched-capacitor sampling array and into block RAM. The array holds eight physical channels of `CELLS` cells each. These channels can be chained so that fewer logical channels each get a deeper record: one, two, four or eight times the base depth. A host sets up a cascade code, a readout start mode, a channel window and the cell at which sampling stopped. It then pulses a start input. The sequencer emits one address pair per clock with a valid strobe and ends with a done pulse.

Readout can begin at cell 0 or at the stop cell. In the second case the cell index wraps modulo the cascaded depth, so the record comes out in time order. The channel window is walked from the first address to the last, one full record per channel. All configuration is captured on the start pulse. After that, the inputs may change freely while a readout is running.

Top module: `rdseq_top`

## Requirements
- R1: After reset, `valid_o` and `done_o` are low and `cell_o` and `chan_o` are zero.
- R2: A start pulse seen while idle makes `valid_o` high on the next cycle, with `chan_o` at the effective first channel and `cell_o` at the start cell.
- R3: The cascaded depth is chosen by `casc_cfg_i`: 0xFF gives CELLS, 0x33 gives 2*CELLS, 0x11 gives 4*CELLS and 0x01 gives 8*CELLS. Any other code gives CELLS.
- R4: With `stop_mode_i`=0, each channel's record runs through cells 0, 1, ..., depth-1.
- R5: With `stop_mode_i`=1, each channel's record starts at `stop_cell_i` modulo depth, counts up by one, and wraps from depth-1 to 0. Every channel starts again at that same cell.
- R6: Channels are visited in ascending order from the effective first through the effective last, inclusive. Each channel gets exactly depth consecutive valid cycles.
- R7: A channel address above 9 is taken as 9. If the effective last channel is below the effective first, only the first channel is read.
- R8: `done_o` is a one-cycle pulse in the cycle right after the last valid sample, and `valid_o` is low in that cycle.
- R9: A start pulse during a readout is ignored, and so are changes to the mode, cascade, channel or stop-cell inputs during a readout.
- R10: Between start and done, `valid_o` stays high with no gaps, for exactly depth times the channel count cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a readout (acted on only when idle) |
| stop_mode_i | input | 1 | 0: start at cell 0, 1: start at the stop cell |
| casc_cfg_i | input | 8 | Cascade code selecting the depth per channel |
| first_ch_i | input | CH_W | First channel address to read |
| last_ch_i | input | CH_W | Last channel address to read |
| stop_cell_i | input | 16 | Cell at which sampling stopped |
| cell_o | output | $clog2(CELLS)+3 | Cell address of the current sample |
| chan_o | output | CH_W | Channel address of the current sample |
| valid_o | output | 1 | The address pair is valid this cycle |
| done_o | output | 1 | Readout finished (one cycle) |

## Verification
The directed cases cover the following:
- a stop cell at depth-1, which wraps on the second sample, separating wrap-modulo-depth from wrap-modulo-base-depth;
- stop cell 0xFFFF, which tests that the high bits are dropped;
- first above last and both above 9, which separate clamping from plain comparison;
- unknown cascade codes, which must fall back to the base depth.

Random cases mix all four cascade codes, both modes and random windows, and each emitted sample is compared with a bench model. Some runs toggle start and scramble every configuration input during the readout, so any path that samples the live inputs instead of the captured values shows up.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  // Cascade code -> log2 of the depth multiplier.
  function automatic logic [1:0] cascade_shift(input logic [7:0] code);
    logic [1:0] s;
    case (code)
      8'h33:   s = 2'd1;
      8'h11:   s = 2'd2;
      8'h01:   s = 2'd3;
      default: s = 2'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/rdseq_cfg.sv
module rdseq_cfg #(
  parameter int CELLS  = 1024,
  parameter int CH_W   = 4,
  parameter int CH_MAX = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            launch,
  input  logic                            stop_mode,
  input  logic [7:0]                      casc_cfg,
  input  logic [CH_W-1:0]                 first_ch,
  input  logic [CH_W-1:0]                 last_ch,
  input  logic [15:0]                     stop_cell,
  output logic [$clog2(CELLS)+2:0]        start_now,
  output logic [CH_W-1:0]                 first_now,
  output logic [$clog2(CELLS)+2:0]        start_q,
  output logic [1:0]                      shift_q,
  output logic [CH_W-1:0]                 last_q
);
  import rdseq_pkg::*;

  localparam int CELL_W = $clog2(CELLS) + 3;
  localparam int DW     = CELL_W + 1;
  localparam logic [CH_W-1:0] CMAX = CH_W'(CH_MAX);

  logic [1:0]        shift_now;
  logic [DW-1:0]     depth_now;
  logic [CELL_W-1:0] mask_now;
  logic [CELL_W-1:0] stop_trunc;
  logic [CH_W-1:0]   last_clip;
  logic [CH_W-1:0]   last_now;

  always_comb begin
    shift_now  = cascade_shift(casc_cfg);
    depth_now  = DW'(CELLS) << shift_now;
    mask_now   = CELL_W'(depth_now - DW'(1));
    stop_trunc = CELL_W'(stop_cell);
    start_now  = stop_mode ? (stop_trunc & mask_now) : '0;
    first_now  = (first_ch > CMAX) ? CMAX : first_ch;
    last_clip  = (last_ch > CMAX) ? CMAX : last_ch;
    last_now   = (last_clip < first_now) ? first_now : last_clip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      shift_q <= '0;
      last_q  <= '0;
    end else if (launch) begin
      start_q <= start_now;
      shift_q <= shift_now;
      last_q  <= last_now;
    end
  end

  // R7: the captured window end never exceeds the channel ceiling
  assert_last_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (last_q <= CMAX));

endmodule

// File: rtl/rdseq_cell.sv
module rdseq_cell #(
  parameter int CELLS = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     launch,
  input  logic                     run,
  input  logic [$clog2(CELLS)+2:0] start_now,
  input  logic [$clog2(CELLS)+2:0] start_q,
  input  logic [1:0]               shift_q,
  output logic [$clog2(CELLS)+2:0] cell_q,
  output logic                     last_cell
);
  localparam int CELL_W = $clog2(CELLS) + 3;
  localparam int DW     = CELL_W + 1;

  logic [DW-1:0]     depth;
  logic [CELL_W-1:0] mask;
  logic [CELL_W-1:0] cnt_q;

  always_comb begin
    depth     = DW'(CELLS) << shift_q;
    mask      = CELL_W'(depth - DW'(1));
    last_cell = (cnt_q == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cell_q <= '0;
    end else if (launch) begin
      cnt_q  <= '0;
      cell_q <= start_now;
    end else if (run) begin
      if (last_cell) begin
        cnt_q  <= '0;
        cell_q <= start_q;
      end else begin
        cnt_q  <= cnt_q + CELL_W'(1);
        cell_q <= (cell_q + CELL_W'(1)) & mask;
      end
    end
  end

  // R5: the emitted cell always lies inside the cascaded depth
  assert_cell_in_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ((cell_q & ~mask) == '0));

  // R5: each channel's record restarts at the captured start cell
  assert_record_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && last_cell) |=> (cell_q == start_q));

endmodule

// File: rtl/rdseq_chan.sv
module rdseq_chan #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            run,
  input  logic            advance,
  input  logic [CH_W-1:0] first_now,
  input  logic [CH_W-1:0] last_q,
  output logic [CH_W-1:0] chan_q,
  output logic            last_chan
);
  assign last_chan = (chan_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chan_q <= '0;
    else if (launch)
      chan_q <= first_now;
    else if (advance && !last_chan)
      chan_q <= chan_q + CH_W'(1);
  end

  // R6: channel never passes the window end during a readout
  assert_chan_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (chan_q <= last_q));

  // R6: channel address only holds or rises by one while running
  assert_chan_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !advance) |=> (chan_q == $past(chan_q)));

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top #(
  parameter int CELLS  = 1024,
  parameter int CH_W   = 4,
  parameter int CH_MAX = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     stop_mode_i,
  input  logic [7:0]               casc_cfg_i,
  input  logic [CH_W-1:0]          first_ch_i,
  input  logic [CH_W-1:0]          last_ch_i,
  input  logic [15:0]              stop_cell_i,
  output logic [$clog2(CELLS)+2:0] cell_o,
  output logic [CH_W-1:0]          chan_o,
  output logic                     valid_o,
  output logic                     done_o
);
  localparam int CELL_W = $clog2(CELLS) + 3;

  logic              run_q;
  logic              done_q;
  logic              launch;
  logic              last_cell;
  logic              last_chan;
  logic              finish;
  logic [CELL_W-1:0] start_now;
  logic [CELL_W-1:0] start_q;
  logic [1:0]        shift_q;
  logic [CH_W-1:0]   first_now;
  logic [CH_W-1:0]   last_q;

  // named events for the checks
  assign launch = start_i && !run_q;
  assign finish = run_q && last_cell && last_chan;

  rdseq_cfg #(.CELLS(CELLS), .CH_W(CH_W), .CH_MAX(CH_MAX)) u_cfg (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .stop_mode(stop_mode_i), .casc_cfg(casc_cfg_i),
    .first_ch(first_ch_i), .last_ch(last_ch_i), .stop_cell(stop_cell_i),
    .start_now(start_now), .first_now(first_now),
    .start_q(start_q), .shift_q(shift_q), .last_q(last_q)
  );

  rdseq_cell #(.CELLS(CELLS)) u_cell (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(run_q),
    .start_now(start_now), .start_q(start_q), .shift_q(shift_q),
    .cell_q(cell_o), .last_cell(last_cell)
  );

  rdseq_chan #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(run_q),
    .advance(run_q && last_cell), .first_now(first_now), .last_q(last_q),
    .chan_q(chan_o), .last_chan(last_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (launch)
        run_q <= 1'b1;
      else if (finish)
        run_q <= 1'b0;
    end
  end

  assign valid_o = run_q;
  assign done_o  = done_q;

  // R2: an idle start brings up valid on the first clamped channel
  assert_launch_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_o) |=> (valid_o && chan_o == $past(first_now)));

  // R8: done lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: done only directly after a valid sample, never with one
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!valid_o && $past(valid_o)));

  // R9 / R10: start during a readout does not break the valid run
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && valid_o && !finish) |=> valid_o);

endmodule

// File: tb/rdseq_top_tb.sv
module rdseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS  = 8;
  localparam int CH_W   = 4;
  localparam int CH_MAX = 9;
  localparam int CELL_W = $clog2(CELLS) + 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              stop_mode_i = 1'b0;
  logic [7:0]        casc_cfg_i = 8'hFF;
  logic [CH_W-1:0]   first_ch_i = '0;
  logic [CH_W-1:0]   last_ch_i = '0;
  logic [15:0]       stop_cell_i = '0;
  logic [CELL_W-1:0] cell_o;
  logic [CH_W-1:0]   chan_o;
  logic              valid_o;
  logic              done_o;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  rdseq_top #(.CELLS(CELLS), .CH_W(CH_W), .CH_MAX(CH_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_mode_i(stop_mode_i),
    .casc_cfg_i(casc_cfg_i), .first_ch_i(first_ch_i), .last_ch_i(last_ch_i),
    .stop_cell_i(stop_cell_i), .cell_o(cell_o), .chan_o(chan_o),
    .valid_o(valid_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bench_depth(input logic [7:0] code);
    if (code == 8'h01) return CELLS * 8;
    if (code == 8'h11) return CELLS * 4;
    if (code == 8'h33) return CELLS * 2;
    return CELLS;
  endfunction

  function automatic int clip(input int a);
    return (a > CH_MAX) ? CH_MAX : a;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input bit md, input logic [7:0] cfg, input int f,
                          input int l, input logic [15:0] st, input bit disturb);
    int d  = bench_depth(cfg);
    int fe = clip(f);
    int le = clip(l);
    int s0 = md ? (int'(st) % d) : 0;
    string rq = md ? "R5" : "R4";
    if (le < fe) le = fe;
    stop_mode_i = md; casc_cfg_i = cfg; first_ch_i = CH_W'(f);
    last_ch_i = CH_W'(l); stop_cell_i = st; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int ch = fe; ch <= le; ch++) begin
      for (int k = 0; k < d; k++) begin
        int ec = (s0 + k) % d;
        check(valid_o === 1'b1, "R10", "valid during record", int'(valid_o), 1);
        check(cell_o == CELL_W'(ec), rq, "cell (R3 depth)", int'(cell_o), ec);
        check(chan_o == CH_W'(ch), "R6", "channel", int'(chan_o), ch);
        if (disturb) begin  // R9: scramble inputs mid-readout
          start_i = 1'($urandom % 2);
          stop_mode_i = 1'($urandom % 2);
          casc_cfg_i = 8'($urandom);
          first_ch_i = CH_W'($urandom);
          last_ch_i = CH_W'($urandom);
          stop_cell_i = 16'($urandom);
        end
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    check(done_o === 1'b1, "R8", "done after last sample", int'(done_o), 1);
    check(valid_o === 1'b0, "R8", "valid low with done", int'(valid_o), 0);
    @(negedge clk);
    check(done_o === 1'b0, "R8", "done single cycle", int'(done_o), 0);
    check(valid_o === 1'b0, "R9", "no relaunch from ignored start", int'(valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] codes [4] = '{8'hFF, 8'h33, 8'h11, 8'h01};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o === 1'b0 && done_o === 1'b0, "R1", "valid/done at reset",
          int'({valid_o, done_o}), 0);
    check(cell_o == '0 && chan_o == '0, "R1", "addresses at reset",
          int'(cell_o) + int'(chan_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o === 1'b0, "R1", "idle after reset", int'(valid_o), 0);

    // directed corners
    run_case(1'b0, 8'hFF, 0, 7, 16'd0, 1'b0);          // R4 all physical
    run_case(1'b1, 8'h01, 2, 3, 16'(CELLS*8-1), 1'b0); // R5 wrap at once
    run_case(1'b1, 8'h33, 1, 1, 16'hFFFF, 1'b0);       // R5 high bits dropped
    run_case(1'b1, 8'h11, 0, 0, 16'd5, 1'b0);          // R3 4x
    run_case(1'b0, 8'h00, 3, 4, 16'd0, 1'b0);          // R3 unknown code
    run_case(1'b1, 8'h3F, 0, 0, 16'd13, 1'b0);         // R3 unknown code
    run_case(1'b0, 8'hFF, 6, 2, 16'd0, 1'b0);          // R7 last < first
    run_case(1'b0, 8'hFF, 15, 15, 16'd0, 1'b0);        // R7 both clamped
    run_case(1'b1, 8'hFF, 7, 12, 16'd3, 1'b0);         // R7 last clamped
    run_case(1'b1, 8'h33, 0, 3, 16'd9, 1'b1);          // R9 disturbed
    run_case(1'b0, 8'h01, 1, 2, 16'd0, 1'b1);          // R9 disturbed

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [7:0] cf = (($urandom % 6) == 0) ? 8'($urandom) : codes[$urandom % 4];
      run_case(1'($urandom % 2), cf, int'($urandom % 12), int'($urandom % 12),
               16'($urandom), 1'($urandom % 3 == 0));
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule